// File: doc/BRIEF.md
# Accumulator ALU Execute Core

This block is the arithmetic loop of a simple processor datapath. An accumulator register drives the A side of a small ALU, an external operand drives the B side, and the ALU result is written back into the accumulator. A single load strobe therefore performs a complete read-modify-write of the accumulator. A 2-bit function code selects one of four operations: add, subtract, bitwise AND or bitwise OR.

A sequencer, or a testbench, steps the core one operation per clock. A synchronous clear empties the accumulator. The zero and carry/borrow flags describe the result that is about to be loaded, so a controller can test them before it commits the write. Bus arbitration, memory and instruction decoding are handled outside this block.

Top module: `acc_exec_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator becomes 0x00. Reset is synchronous and active-low.
- R2: Function code 00 is add. With `ld` high and `clr` low, the accumulator loads (acc + opnd) mod 256 at the rising edge.
- R3: Function code 01 is subtract. With `ld` high and `clr` low, the accumulator loads (acc − opnd) mod 256 at the rising edge.
- R4: Function code 10 is bitwise AND. With `ld` high and `clr` low, the accumulator loads acc & opnd.
- R5: Function code 11 is bitwise OR. With `ld` high and `clr` low, the accumulator loads acc | opnd.
- R6: With `ld` low and `clr` low, the accumulator keeps its value at a rising edge, whatever the function code and operand.
- R7: With `clr` high at a rising edge, the accumulator becomes 0x00, even when `ld` is also high.
- R8: `zero` is combinational. It is 1 exactly when the current ALU result (the value a load would write) is 0x00.
- R9: `cy` is combinational. For add it is the carry out of bit 7. For subtract it is 1 when opnd > acc (unsigned borrow). For AND and OR it is 0.
- R10: The sequence clear, add 5, add 10, subtract 15 leaves the accumulator at 0, 5, 15 and 0 in turn, with `zero` high during the subtract step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the accumulator; takes priority over `ld` |
| ld | input | 1 | Write the ALU result into the accumulator at the next edge |
| fsel | input | 2 | Function code: 00 add, 01 subtract, 10 AND, 11 OR |
| opnd | input | 8 | Operand for ALU input B |
| acc | output | 8 | Current accumulator value |
| zero | output | 1 | ALU result is 0x00 |
| cy | output | 1 | Carry out (add) or borrow (subtract); 0 for logic functions |

## Verification
Some states can only be reached by first loading the accumulator with a chosen value, because the accumulator is always one of the ALU inputs. Examples are a subtract that borrows, an add that wraps to exactly zero, and a logic result of zero that comes from a nonzero accumulator. The vector table reaches these states by chaining operations: it loads 0xFF through an add and then adds 0x01, it subtracts from zero, and it sums 0x80 twice. The bench also raises `clr` and `ld` together while the accumulator holds a nonzero value, which tests the clear priority. Reset is applied while a load is requested.

// File: rtl/acc_core_pkg.sv
// Package: shared function codes for the accumulator execute core.
// Assumes a 2-bit function select; the codes are fixed by the core's interface.
package acc_core_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_AND = 2'b10,
        FN_OR  = 2'b11
    } alu_fn_e;

    // True when the function uses the adder path (codes with bit 1 clear).
    function automatic logic fn_is_arith(input alu_fn_e fn);
        return (fn == FN_ADD) || (fn == FN_SUB);
    endfunction

endpackage

// File: rtl/acc_addsub.sv
// Module: acc_addsub
// A ripple adder/subtractor built from one full-adder slice per bit.
// For subtract it adds the inverted B plus one. The flag output is the carry
// for add and the borrow (inverted carry) for subtract.
// Assumes DW >= 1. The result is purely combinational.
module acc_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          flag
);

    logic [DW:0]   carry;
    logic [DW-1:0] b_eff;

    // Purpose: the carry-in is the subtract's "+1".
    assign carry[0] = sub;

    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_slice
            // Purpose: one full-adder slice with a conditional invert on B.
            always_comb begin
                b_eff[g]    = b[g] ^ sub;
                sum[g]      = a[g] ^ b_eff[g] ^ carry[g];
                carry[g+1]  = (a[g] & b_eff[g]) | (carry[g] & (a[g] ^ b_eff[g]));
            end
        end
    endgenerate

    // Purpose: report carry for add, borrow for subtract.
    assign flag = sub ? ~carry[DW] : carry[DW];

endmodule

// File: rtl/acc_logic_unit.sv
// Module: acc_logic_unit
// Bitwise AND or OR of the two operands, chosen by sel_or.
// Assumes equal operand widths. Purely combinational.
module acc_logic_unit #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sel_or,
    output logic [DW-1:0] res
);

    genvar g;
    generate
        for (g = 0; g < DW; g++) begin : g_bit
            // Purpose: per-bit choice between AND and OR.
            assign res[g] = sel_or ? (a[g] | b[g]) : (a[g] & b[g]);
        end
    endgenerate

endmodule

// File: rtl/acc_alu.sv
// Module: acc_alu
// Four-function ALU: add, subtract, AND, OR. It drives the result, a zero
// flag and a carry/borrow flag. Bit 1 of the function code picks the logic
// path and bit 0 picks the sub-operation.
// Assumes the function codes from acc_core_pkg. Purely combinational.
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    fsel,
    output logic [DW-1:0] res,
    output logic          zero,
    output logic          cy
);

    alu_fn_e       fn;
    logic [DW-1:0] arith_res;
    logic [DW-1:0] logic_res;
    logic          arith_flag;

    // Purpose: give the raw select its enumerated meaning.
    assign fn = alu_fn_e'(fsel);

    acc_addsub #(.DW(DW)) i_addsub (
        .a    (a),
        .b    (b),
        .sub  (fn == FN_SUB),
        .sum  (arith_res),
        .flag (arith_flag)
    );

    acc_logic_unit #(.DW(DW)) i_logic (
        .a      (a),
        .b      (b),
        .sel_or (fn == FN_OR),
        .res    (logic_res)
    );

    // Purpose: select the result path and form both flags.
    always_comb begin
        if (fn_is_arith(fn)) begin
            res = arith_res;
            cy  = arith_flag;
        end else begin
            res = logic_res;
            cy  = 1'b0;
        end
        zero = (res == '0);
    end

    // R9: a logic function never reports carry
    a_r9_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        fsel[1] |-> !cy);

    // R9: an add with operand zero cannot carry
    a_r9_add_zero_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == 2'b00 && b == '0) |-> (!cy && res == a));

endmodule

// File: rtl/acc_register.sv
// Module: acc_register
// The accumulator storage. Synchronous active-low reset, synchronous clear
// with priority over load, and hold when neither is active.
// Assumes one clock domain.
module acc_register #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    // Purpose: update the accumulator: reset, then clear, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/acc_exec_core.sv
// Module: acc_exec_core (top)
// The accumulator drives ALU input A, the operand drives input B, and the
// ALU result returns to the accumulator on a load strobe. Clear overrides load.
// The zero and carry flags describe the result that a load would write.
// Assumes synchronous use: inputs are stable around the rising edge.
module acc_exec_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [1:0]    fsel,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] acc,
    output logic          zero,
    output logic          cy
);

    logic [DW-1:0] alu_res;

    acc_alu #(.DW(DW)) i_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (acc),
        .b     (opnd),
        .fsel  (fsel),
        .res   (alu_res),
        .zero  (zero),
        .cy    (cy)
    );

    acc_register #(.DW(DW)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ld    (ld),
        .d     (alu_res),
        .q     (acc)
    );

    // R6: no load and no clear means the accumulator holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr) |=> $stable(acc));

    // R7: clear empties the accumulator regardless of the load strobe
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R2: a load commits the ALU result that was presented
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (acc == $past(alu_res)));

    // R8: the zero flag before a load predicts a zero accumulator after it
    a_r8_zero_predicts: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> ((acc == '0) == $past(zero)));

    // R3: subtract loads the wrapped difference
    a_r3_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr && fsel == 2'b01) |=> (acc == DW'($past(acc) - $past(opnd))));

endmodule

// File: tb/test_acc_exec_core.sv
// Bench for acc_exec_core: a vector table walked by one loop, then directed
// tests for reset and the clear priority.
module test_acc_exec_core;

    typedef struct packed {
        logic       clr;
        logic       ld;
        logic [1:0] fs;
        logic [7:0] op;
        logic       z;     // expected zero flag before the edge
        logic       c;     // expected carry/borrow before the edge
        logic [7:0] acc;   // expected accumulator after the edge
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'b00, 8'h33, 1'b0, 1'b0, 8'h00}, // R7 R10 clear beats load
        '{1'b0, 1'b1, 2'b00, 8'h05, 1'b0, 1'b0, 8'h05}, // R10 add 5
        '{1'b0, 1'b1, 2'b00, 8'h0A, 1'b0, 1'b0, 8'h0F}, // R10 add 10
        '{1'b0, 1'b1, 2'b01, 8'h0F, 1'b1, 1'b0, 8'h00}, // R10 R3 subtract 15, zero
        '{1'b0, 1'b1, 2'b00, 8'hFF, 1'b0, 1'b0, 8'hFF}, // R2
        '{1'b0, 1'b1, 2'b00, 8'h01, 1'b1, 1'b1, 8'h00}, // R2 R9 wrap to zero
        '{1'b0, 1'b1, 2'b01, 8'h01, 1'b0, 1'b1, 8'hFF}, // R3 R9 borrow
        '{1'b0, 1'b0, 2'b00, 8'h10, 1'b0, 1'b1, 8'hFF}, // R6 hold
        '{1'b0, 1'b1, 2'b10, 8'h3C, 1'b0, 1'b0, 8'h3C}, // R4 AND
        '{1'b0, 1'b1, 2'b11, 8'hC1, 1'b0, 1'b0, 8'hFD}, // R5 OR
        '{1'b0, 1'b1, 2'b10, 8'h02, 1'b1, 1'b0, 8'h00}, // R8 R4 zero from logic
        '{1'b0, 1'b1, 2'b11, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 R8
        '{1'b0, 1'b1, 2'b00, 8'h80, 1'b0, 1'b0, 8'h80}, // R2
        '{1'b0, 1'b1, 2'b00, 8'h80, 1'b1, 1'b1, 8'h00}, // R2 R9 carry to zero
        '{1'b0, 1'b0, 2'b11, 8'h5A, 1'b0, 1'b0, 8'h00}  // R6 hold at zero
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       ld = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic [7:0] opnd = 8'h00;
    logic [7:0] acc;
    logic       zero;
    logic       cy;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5ns clk = ~clk;

    acc_exec_core #(.DW(8)) i_acc_exec_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ld    (ld),
        .fsel  (fsel),
        .opnd  (opnd),
        .acc   (acc),
        .zero  (zero),
        .cy    (cy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check flags, then check acc one edge later.
    task automatic step(input vec_t v, input int idx);
        clr  = v.clr;
        ld   = v.ld;
        fsel = v.fs;
        opnd = v.op;
        #1ns;
        check($sformatf("R8 zero vec %0d", idx), {7'b0, zero}, {7'b0, v.z});
        check($sformatf("R9 cy vec %0d", idx), {7'b0, cy}, {7'b0, v.c});
        @(negedge clk);
        check($sformatf("R2-table acc vec %0d", idx), acc, v.acc);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 acc in reset", acc, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i], i);
        end

        // R1: reset wins over a pending load
        step('{1'b0, 1'b1, 2'b00, 8'h55, 1'b0, 1'b0, 8'h55}, 100);
        rst_n = 1'b0;
        ld    = 1'b1;
        fsel  = 2'b11;
        opnd  = 8'hAA;
        @(negedge clk);
        check("R1 reset with load", acc, 8'h00);
        rst_n = 1'b1;
        ld    = 1'b0;

        // R7: clear with load high from a nonzero value
        step('{1'b0, 1'b1, 2'b11, 8'h81, 1'b0, 1'b0, 8'h81}, 101);
        step('{1'b1, 1'b1, 2'b00, 8'h01, 1'b0, 1'b0, 8'h00}, 102);
        check("R7 clear priority", acc, 8'h00);

        // R3: subtract to equal values gives zero with no borrow
        step('{1'b0, 1'b1, 2'b00, 8'h42, 1'b0, 1'b0, 8'h42}, 103);
        step('{1'b0, 1'b1, 2'b01, 8'h42, 1'b1, 1'b0, 8'h00}, 104);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule